// File: doc/BRIEF.md
# SD card identification sequencer

This block walks a freshly inserted SD or MMC card through its bring-up command sequence and leaves it selected with a known block length. It never drives the card line itself. Each command goes out through a request/response handshake to a separate command engine. The sequencer presents a command index and a 32-bit argument. The engine answers with a one-cycle response strobe, a 2-bit status and a 32-bit response word. A second handshake asks the engine to soft-reset its command line after a probe command that the card did not answer.

Along the way the sequencer sorts the card into one of five kinds: I/O-only card, MMC, SD version 1, SD version 2 standard capacity, or SD version 2 high capacity. It learns the card's relative address, then reads the card-specific data, selects the card and programs the block length. The operating-conditions loop is polled with a programmable wait between tries and a retry limit. Every abort leaves an error code that names the step that failed.

Top module: `sd_ident_seq`

## Requirements
- R1: A `start` pulse in the idle or finished state issues CMD0 with argument 0, then CMD5 with argument 0. If CMD5 succeeds, the sequence finishes with card type 1 (I/O card) and error code 1 (unsupported), and no further command is issued.
- R2: When CMD5 fails, `srst_req` rises and stays high until `srst_done` is seen. CMD8 with argument VCHK_PATTERN then follows. When CMD8 fails, the same soft-reset handshake runs and CMD55 follows. A probe that succeeds causes no soft reset.
- R3: If CMD8 succeeds but its response differs from VCHK_PATTERN, the sequence finishes with error code 2. An exact echo marks the card as version 2.
- R4: If CMD55 fails, CMD1 with argument 0 is issued. If CMD1 succeeds, the sequence finishes with card type 2 (MMC) and error code 1. If CMD1 fails, it finishes with error code 6.
- R5: After a successful CMD55, CMD41 is issued. Its argument is the stored operating-conditions word (OCR_INIT after `start`), with bit 30 forced to 1 only for a version 2 card. Each CMD41 response replaces the stored word. CMD41 is only ever issued right after CMD55.
- R6: A CMD41 response with bit 31 clear counts as one try. After MAX_TRIES such tries the sequence finishes with error code 3. Otherwise the next CMD55 request rises exactly WAIT_CYCLES+1 cycles after the cycle in which that response was accepted.
- R7: A CMD41 response with bit 31 set classifies the card. A card that is not version 2 becomes type 3. A version 2 card becomes type 5 when response bit 30 is set, and type 4 otherwise.
- R8: After classification, CMD2 and then CMD3 are issued, both with argument 0. `rca` takes CMD3 response bits 31:16.
- R9: CMD9 and then CMD7 are issued with argument {rca, 16'h0000}, followed by CMD16 with argument BLOCK_LEN. When CMD16 succeeds, `done`=1, `ready`=1 and error code 0.
- R10: A non-zero status (1 = error, 2 = timeout; 0 = success) outside the probe commands aborts with a step code: CMD0 gives 4, CMD41 gives 5, CMD2 gives 7, CMD3 gives 8, CMD9 gives 9, CMD7 gives 10, CMD16 gives 11.
- R11: Reset and each accepted `start` clear `done`, `ready`, `card_type`, `rca` and `err_code` to 0. After reset, no request is pending.
- R12: `cmd_req` holds with `cmd_idx` and `cmd_arg` stable until `cmd_rsp_valid`, and drops on the following cycle. `cmd_req` and `srst_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | begin a sequence (idle or finished state only) |
| cmd_req | output | 1 | command request to the command engine |
| cmd_idx | output | 6 | command index |
| cmd_arg | output | 32 | command argument |
| cmd_rsp_valid | input | 1 | one-cycle response strobe |
| cmd_rsp_status | input | 2 | 0 success, 1 error, 2 timeout |
| cmd_rsp_data | input | 32 | response word |
| srst_req | output | 1 | command-line soft reset request |
| srst_done | input | 1 | soft reset finished |
| done | output | 1 | sequence finished (held until next start) |
| ready | output | 1 | card selected and configured |
| card_type | output | 3 | 0 none, 1 I/O, 2 MMC, 3 SD v1, 4 SD v2 standard, 5 SD v2 high capacity |
| rca | output | 16 | relative card address |
| err_code | output | 4 | 0 none, otherwise failing step (see R3, R4, R6, R10) |

## Verification
The handshake assertions assume the command engine raises `cmd_rsp_valid` for exactly one cycle, and only while `cmd_req` is high. They also assume `srst_done` is low whenever a soft reset is newly requested. The bench's responder waits for a request before answering, drops its strobe after one cycle, and lowers `srst_done` as soon as `srst_req` falls. Within those rules, the stimulus sweeps every combination of probe outcome, echo fault, MMC path, capacity bit, number of not-ready tries and failing step.

// File: rtl/sd_ident_pkg.sv
package sd_ident_pkg;

  // command indices used by the sequence
  localparam logic [5:0] CMD_GO_IDLE  = 6'd0;
  localparam logic [5:0] CMD_OP_COND  = 6'd1;
  localparam logic [5:0] CMD_ALL_CID  = 6'd2;
  localparam logic [5:0] CMD_REL_ADDR = 6'd3;
  localparam logic [5:0] CMD_IO_PROBE = 6'd5;
  localparam logic [5:0] CMD_SELECT   = 6'd7;
  localparam logic [5:0] CMD_VOLT_CHK = 6'd8;
  localparam logic [5:0] CMD_GET_CSD  = 6'd9;
  localparam logic [5:0] CMD_SET_BLK  = 6'd16;
  localparam logic [5:0] CMD_SD_OP    = 6'd41;
  localparam logic [5:0] CMD_APP      = 6'd55;

  localparam logic [1:0] RSP_OK = 2'd0;

  typedef enum logic [2:0] {
    CT_NONE = 3'd0, CT_IO = 3'd1, CT_MMC = 3'd2,
    CT_SD1 = 3'd3, CT_SD2_STD = 3'd4, CT_SD2_HC = 3'd5
  } card_e;

  typedef enum logic [3:0] {
    E_NONE = 4'd0, E_UNSUP = 4'd1, E_ECHO = 4'd2, E_LOOP_TMO = 4'd3,
    E_CMD0 = 4'd4, E_CMD41 = 4'd5, E_CMD1 = 4'd6, E_CMD2 = 4'd7,
    E_CMD3 = 4'd8, E_CMD9 = 4'd9, E_CMD7 = 4'd10, E_CMD16 = 4'd11
  } err_e;

  typedef enum logic [2:0] {
    F_IDLE, F_CMD, F_EVAL, F_SRST, F_WAIT, F_DONE
  } fsm_e;

endpackage

// File: rtl/ident_count.sv
module ident_count #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_last
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && !at_last)
      cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/sd_ident_seq.sv
module sd_ident_seq
  import sd_ident_pkg::*;
#(
  parameter int          WAIT_CYCLES  = 200000,
  parameter int          MAX_TRIES    = 1000,
  parameter int          BLOCK_LEN    = 512,
  parameter logic [31:0] VCHK_PATTERN = 32'h0000_01AA,
  parameter logic [31:0] OCR_INIT     = 32'h00FF_8000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        cmd_req,
  output logic [5:0]  cmd_idx,
  output logic [31:0] cmd_arg,
  input  logic        cmd_rsp_valid,
  input  logic [1:0]  cmd_rsp_status,
  input  logic [31:0] cmd_rsp_data,
  output logic        srst_req,
  input  logic        srst_done,
  output logic        done,
  output logic        ready,
  output logic [2:0]  card_type,
  output logic [15:0] rca,
  output logic [3:0]  err_code
);
  localparam logic [31:0] BLK_ARG = 32'(BLOCK_LEN);
  localparam int          BUSY_BIT = 31;
  localparam int          CAP_BIT  = 30;

  fsm_e        state;
  logic        v2_card;
  logic [31:0] ocr_word;
  logic [31:0] rsp_q;
  logic        ok_q;
  logic        wait_done;
  logic        try_last;
  logic        try_inc;
  logic        begin_seq;

  assign begin_seq = start && (state == F_IDLE || state == F_DONE);
  assign try_inc   = (state == F_EVAL) && (cmd_idx == CMD_SD_OP) && ok_q && !rsp_q[BUSY_BIT];

  ident_count #(.LIMIT(WAIT_CYCLES)) u_wait (
    .clk(clk), .rst(rst), .clr(state != F_WAIT), .inc(1'b1), .at_last(wait_done)
  );

  ident_count #(.LIMIT(MAX_TRIES)) u_tries (
    .clk(clk), .rst(rst), .clr(begin_seq), .inc(try_inc), .at_last(try_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= F_IDLE;
      cmd_req   <= 1'b0;
      cmd_idx   <= CMD_GO_IDLE;
      cmd_arg   <= '0;
      srst_req  <= 1'b0;
      done      <= 1'b0;
      ready     <= 1'b0;
      card_type <= CT_NONE;
      rca       <= '0;
      err_code  <= E_NONE;
      v2_card   <= 1'b0;
      ocr_word  <= OCR_INIT;
      rsp_q     <= '0;
      ok_q      <= 1'b0;
    end else begin
      case (state)
        F_IDLE, F_DONE: begin
          if (start) begin
            done      <= 1'b0;
            ready     <= 1'b0;
            card_type <= CT_NONE;
            rca       <= '0;
            err_code  <= E_NONE;
            v2_card   <= 1'b0;
            ocr_word  <= OCR_INIT;
            cmd_idx   <= CMD_GO_IDLE;
            cmd_arg   <= '0;
            cmd_req   <= 1'b1;
            state     <= F_CMD;
          end
        end
        F_CMD: begin
          if (cmd_rsp_valid) begin
            cmd_req <= 1'b0;
            rsp_q   <= cmd_rsp_data;
            ok_q    <= (cmd_rsp_status == RSP_OK);
            state   <= F_EVAL;
          end
        end
        F_EVAL: begin
          // default: launch the next command with a zero argument
          cmd_req <= 1'b1;
          cmd_arg <= '0;
          state   <= F_CMD;
          case (cmd_idx)
            CMD_GO_IDLE: begin
              if (ok_q) cmd_idx <= CMD_IO_PROBE;
              else begin cmd_req <= 1'b0; done <= 1'b1; err_code <= E_CMD0; state <= F_DONE; end
            end
            CMD_IO_PROBE: begin
              if (ok_q) begin
                cmd_req <= 1'b0; done <= 1'b1; card_type <= CT_IO; err_code <= E_UNSUP; state <= F_DONE;
              end else begin
                cmd_req <= 1'b0; srst_req <= 1'b1; cmd_idx <= CMD_VOLT_CHK; state <= F_SRST;
              end
            end
            CMD_VOLT_CHK: begin
              if (!ok_q) begin
                cmd_req <= 1'b0; srst_req <= 1'b1; cmd_idx <= CMD_APP; state <= F_SRST;
              end else if (rsp_q != VCHK_PATTERN) begin
                cmd_req <= 1'b0; done <= 1'b1; err_code <= E_ECHO; state <= F_DONE;
              end else begin
                v2_card <= 1'b1; cmd_idx <= CMD_APP;
              end
            end
            CMD_APP: begin
              if (ok_q) begin
                cmd_idx <= CMD_SD_OP;
                cmd_arg <= ocr_word | (32'(v2_card) << CAP_BIT);
              end else cmd_idx <= CMD_OP_COND;
            end
            CMD_OP_COND: begin
              cmd_req <= 1'b0; done <= 1'b1; state <= F_DONE;
              if (ok_q) begin card_type <= CT_MMC; err_code <= E_UNSUP; end
              else err_code <= E_CMD1;
            end
            CMD_SD_OP: begin
              if (!ok_q) begin
                cmd_req <= 1'b0; done <= 1'b1; err_code <= E_CMD41; state <= F_DONE;
              end else begin
                ocr_word <= rsp_q;
                if (rsp_q[BUSY_BIT]) begin
                  cmd_idx   <= CMD_ALL_CID;
                  card_type <= !v2_card ? CT_SD1 : (rsp_q[CAP_BIT] ? CT_SD2_HC : CT_SD2_STD);
                end else if (try_last) begin
                  cmd_req <= 1'b0; done <= 1'b1; err_code <= E_LOOP_TMO; state <= F_DONE;
                end else begin
                  cmd_req <= 1'b0; state <= F_WAIT;
                end
              end
            end
            CMD_ALL_CID: begin
              if (ok_q) cmd_idx <= CMD_REL_ADDR;
              else begin cmd_req <= 1'b0; done <= 1'b1; err_code <= E_CMD2; state <= F_DONE; end
            end
            CMD_REL_ADDR: begin
              if (ok_q) begin
                rca     <= rsp_q[31:16];
                cmd_idx <= CMD_GET_CSD;
                cmd_arg <= {rsp_q[31:16], 16'h0000};
              end else begin cmd_req <= 1'b0; done <= 1'b1; err_code <= E_CMD3; state <= F_DONE; end
            end
            CMD_GET_CSD: begin
              if (ok_q) begin cmd_idx <= CMD_SELECT; cmd_arg <= {rca, 16'h0000}; end
              else begin cmd_req <= 1'b0; done <= 1'b1; err_code <= E_CMD9; state <= F_DONE; end
            end
            CMD_SELECT: begin
              if (ok_q) begin cmd_idx <= CMD_SET_BLK; cmd_arg <= BLK_ARG; end
              else begin cmd_req <= 1'b0; done <= 1'b1; err_code <= E_CMD7; state <= F_DONE; end
            end
            default: begin
              cmd_req <= 1'b0; done <= 1'b1; state <= F_DONE;
              if (ok_q) ready <= 1'b1;
              else err_code <= E_CMD16;
            end
          endcase
        end
        F_SRST: begin
          if (srst_done) begin
            srst_req <= 1'b0;
            cmd_req  <= 1'b1;
            cmd_arg  <= (cmd_idx == CMD_VOLT_CHK) ? VCHK_PATTERN : 32'h0;
            state    <= F_CMD;
          end
        end
        F_WAIT: begin
          if (wait_done) begin
            cmd_req <= 1'b1;
            cmd_idx <= CMD_APP;
            cmd_arg <= '0;
            state   <= F_CMD;
          end
        end
        default: state <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_ident_seq_chk.sv
module sd_ident_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        cmd_req,
  input logic [5:0]  cmd_idx,
  input logic [31:0] cmd_arg,
  input logic        cmd_rsp_valid,
  input logic [1:0]  cmd_rsp_status,
  input logic [31:0] cmd_rsp_data,
  input logic        srst_req,
  input logic        srst_done,
  input logic        done,
  input logic        ready,
  input logic [2:0]  card_type,
  input logic [15:0] rca,
  input logic [3:0]  err_code
);
  logic [5:0] prev_idx;
  logic       req_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_idx <= 6'd0;
      req_d    <= 1'b0;
    end else begin
      req_d <= cmd_req;
      if (cmd_req && !req_d) prev_idx <= cmd_idx;
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_req && !cmd_rsp_valid |=> cmd_req && $stable(cmd_idx) && $stable(cmd_arg));

  // R12
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_req && cmd_rsp_valid |=> !cmd_req);

  // R12
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_req && srst_req));

  // R5
  app_order_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_req && !req_d && cmd_idx == 6'd41 |-> prev_idx == 6'd55);

  // R9
  ready_ok_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> done && err_code == 4'd0 && card_type >= 3'd3 && card_type <= 3'd5);

  // R1
  io_card_chk: assert property (@(posedge clk) disable iff (rst)
    done && card_type == 3'd1 |-> err_code == 4'd1 && !ready);

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> !cmd_req && !done && !ready && !srst_req && err_code == 4'd0);
endmodule

bind sd_ident_seq sd_ident_seq_chk u_chk (.*);

// File: tb/tb_sd_ident_seq.sv
`timescale 1ns/1ps
module tb_sd_ident_seq;
  localparam int          W     = 8;
  localparam int          TRIES = 3;
  localparam int          BLK   = 512;
  localparam logic [31:0] VCHK  = 32'h0000_01AA;
  localparam logic [31:0] OCR0  = 32'h00FF_8000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cmd_req, srst_req, done, ready;
  logic [5:0]  cmd_idx;
  logic [31:0] cmd_arg;
  logic        cmd_rsp_valid = 1'b0;
  logic [1:0]  cmd_rsp_status = 2'd0;
  logic [31:0] cmd_rsp_data = 32'h0;
  logic        srst_done = 1'b0;
  logic [2:0]  card_type;
  logic [15:0] rca;
  logic [3:0]  err_code;

  sd_ident_seq #(.WAIT_CYCLES(W), .MAX_TRIES(TRIES), .BLOCK_LEN(BLK),
                 .VCHK_PATTERN(VCHK), .OCR_INIT(OCR0)) dut (.*);

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // card model controls
  bit m_io, m_v2, m_bad_echo, m_mmc, m_hc;
  int m_busy, m_fail;
  logic [1:0]  m_kind;
  logic [15:0] m_rca;

  // log of issued commands
  int          log_n = 0;
  logic [5:0]  log_idx [64];
  logic [31:0] log_arg [64];
  int          a41_n = 0;
  int          srst_n = 0;
  bit          gap_pending = 0;
  int          t_rsp = 0;

  // command engine model
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_req) begin
        automatic logic [5:0]  i = cmd_idx;
        automatic logic [31:0] a = cmd_arg;
        automatic logic [1:0]  st = 2'd0;
        automatic logic [31:0] d = 32'h5A5A_0000 | 32'(i);
        automatic bit          nr = 0;
        if (log_n < 64) begin log_idx[log_n] = i; log_arg[log_n] = a; end
        log_n++;
        if (gap_pending) begin
          // R6 wait between tries
          chk(cyc - t_rsp == W + 1, "R6 retry gap", 32'(cyc - t_rsp), 32'(W + 1));
          gap_pending = 0;
        end
        if (i == 6'd5 && !m_io) st = m_kind;
        if (i == 6'd8) begin
          if (!m_v2) st = m_kind;
          d = a ^ (m_bad_echo ? 32'h1 : 32'h0);
        end
        if (i == 6'd55 && m_mmc) st = m_kind;
        if (i == 6'd41) begin
          d = {a41_n >= m_busy, m_hc, 30'h00FF8000 + 30'(a41_n)};
          nr = (a41_n < m_busy);
          a41_n++;
        end
        if (i == 6'd3) d = {m_rca, 16'h0500};
        if (int'(i) == m_fail) st = m_kind;
        repeat (1 + (int'(i) + log_n) % 3) @(negedge clk);
        cmd_rsp_valid = 1'b1; cmd_rsp_status = st; cmd_rsp_data = d;
        @(negedge clk);
        cmd_rsp_valid = 1'b0;
        t_rsp = cyc;
        if (i == 6'd41 && st == 2'd0 && nr) gap_pending = 1;
      end
    end
  end

  // soft reset model
  initial begin
    forever begin
      @(negedge clk);
      if (srst_req && !srst_done) begin
        srst_n++;
        repeat (3) @(negedge clk);
        srst_done = 1'b1;
      end else if (!srst_req) srst_done = 1'b0;
    end
  end

  logic [5:0]  e_idx [64];
  logic [31:0] e_arg [64];
  int          e_n;

  task automatic push(input logic [5:0] i, input logic [31:0] a);
    e_idx[e_n] = i; e_arg[e_n] = a; e_n++;
  endtask

  task automatic run_case(input bit io, input int pv, input bit mmc, input bit hc,
                          input int busy, input int fail, input int seed);
    logic [2:0]  x_type = 3'd0;
    logic [3:0]  x_err = 4'd0;
    logic        x_ready = 1'b0;
    logic [15:0] x_rca = 16'h0;
    int          x_srst = 0;
    logic [31:0] word = OCR0;
    bit          v2 = (pv == 1);
    bit          fin = 0;
    int          k = 0;
    m_io = io; m_v2 = (pv != 0); m_bad_echo = (pv == 2); m_mmc = mmc; m_hc = hc;
    m_busy = busy; m_fail = fail; m_kind = (seed % 2 == 0) ? 2'd1 : 2'd2;
    m_rca = 16'h1000 + 16'(seed);
    e_n = 0;
    // expected sequence from the requirements
    push(6'd0, 32'h0);                                               // R1
    if (fail == 0) begin x_err = 4'd4; fin = 1; end                   // R10
    if (!fin) begin
      push(6'd5, 32'h0);
      if (io) begin x_type = 3'd1; x_err = 4'd1; fin = 1; end         // R1
      else x_srst++;                                                   // R2
    end
    if (!fin) begin
      push(6'd8, VCHK);                                                // R2
      if (pv == 2) begin x_err = 4'd2; fin = 1; end                   // R3
      else if (pv == 0) x_srst++;
    end
    for (int t = 0; !fin; t++) begin
      push(6'd55, 32'h0);
      if (mmc) begin                                                   // R4
        push(6'd1, 32'h0);
        if (fail == 1) x_err = 4'd6;
        else begin x_type = 3'd2; x_err = 4'd1; end
        fin = 1;
      end else begin
        push(6'd41, word | (v2 ? 32'h4000_0000 : 32'h0));             // R5
        if (fail == 41) begin x_err = 4'd5; fin = 1; end
        else begin
          word = {t >= busy, hc, 30'h00FF8000 + 30'(t)};
          if (word[31]) begin                                          // R7
            x_type = !v2 ? 3'd3 : (hc ? 3'd5 : 3'd4);
            break;
          end else if (t + 1 == TRIES) begin x_err = 4'd3; fin = 1; end  // R6
        end
      end
    end
    if (!fin) begin
      push(6'd2, 32'h0);                                               // R8
      if (fail == 2) begin x_err = 4'd7; fin = 1; end
    end
    if (!fin) begin
      push(6'd3, 32'h0);
      if (fail == 3) begin x_err = 4'd8; fin = 1; end
      else x_rca = m_rca;
    end
    if (!fin) begin
      push(6'd9, {x_rca, 16'h0});                                      // R9
      if (fail == 9) begin x_err = 4'd9; fin = 1; end
    end
    if (!fin) begin
      push(6'd7, {x_rca, 16'h0});
      if (fail == 7) begin x_err = 4'd10; fin = 1; end
    end
    if (!fin) begin
      push(6'd16, 32'(BLK));
      if (fail == 16) x_err = 4'd11;
      else x_ready = 1'b1;
    end
    // run
    log_n = 0; a41_n = 0; srst_n = 0; gap_pending = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && k < 4000) begin @(negedge clk); k++; end
    chk(done === 1'b1, "R1 watchdog done", 32'(done), 32'h1);
    if (!done) begin
      rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
    end
    repeat (3) @(negedge clk);
    gap_pending = 0;
    chk(log_n == e_n, "R1 command count", 32'(log_n), 32'(e_n));
    for (int j = 0; j < e_n && j < log_n && j < 64; j++) begin
      chk(log_idx[j] == e_idx[j], "R1 R2 R4 R8 command index", 32'(log_idx[j]), 32'(e_idx[j]));
      chk(log_arg[j] == e_arg[j], "R5 R8 R9 command argument", log_arg[j], e_arg[j]);
    end
    chk(card_type == x_type, "R7 card type", 32'(card_type), 32'(x_type));
    chk(err_code == x_err, "R10 error code", 32'(err_code), 32'(x_err));
    chk(ready == x_ready, "R9 ready", 32'(ready), 32'(x_ready));
    chk(rca == x_rca, "R8 address", 32'(rca), 32'(x_rca));
    chk(srst_n == x_srst, "R2 soft reset count", 32'(srst_n), 32'(x_srst));
  endtask

  localparam int NFAIL = 9;
  int fail_tab [NFAIL] = '{-1, 0, 41, 1, 2, 3, 9, 7, 16};

  initial begin
    int seed = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(cmd_req == 1'b0, "R11 no request", 32'(cmd_req), 32'h0);
    chk(done == 1'b0 && ready == 1'b0, "R11 flags", {30'h0, done, ready}, 32'h0);
    chk(card_type == 3'd0 && err_code == 4'd0 && rca == 16'h0, "R11 outputs",
        {9'h0, card_type, err_code, rca}, 32'h0);
    run_case(1, 0, 0, 0, 0, -1, seed++);
    run_case(1, 0, 0, 0, 0, 0, seed++);
    for (int pv = 0; pv < 3; pv++)
      for (int mm = 0; mm < 2; mm++)
        for (int hc = 0; hc < 2; hc++)
          for (int b = 0; b <= TRIES; b++)
            for (int f = 0; f < NFAIL; f++)
              run_case(0, pv, mm[0], hc[0], b, fail_tab[f], seed++);
    // R11 start clears results of the previous run
    run_case(0, 1, 0, 1, 0, -1, seed++);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(ready == 1'b0 && done == 1'b0 && rca == 16'h0, "R11 cleared by start",
        {14'h0, ready, done, rca}, 32'h0);
    repeat (200) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule